// File: doc/BRIEF.md
# Maintenance Range Chunking Sequencer

This block sits between a software-facing cache maintenance request and a line range engine. A request names an operation (invalidate, clean or flush), a start byte address and an exclusive end byte address. The sequencer turns it into a stream of commands, each either a single-line clean+invalidate or a range command whose end address is inclusive (the address of the last line it touches). Range commands are cut into chunks that are never larger than a set byte budget and never span a page. After the last command has been taken, the block raises a one-cycle completion pulse.

Partial lines are handled per operation. An invalidate must not drop dirty data that shares a line with bytes outside the request, so its ragged head and tail lines are sent as single-line clean+invalidate commands. Clean and flush simply widen the range to whole lines. A write-through override input, sampled when the request is accepted, removes every clean step: a clean request then produces no commands, and a flush produces only its invalidate ranges.

The sequencer is a single state machine. Its states are IDLE (waiting, request accepted here), HEAD (single-line command for a partial first line), TAIL (single-line command for a partial last line), CLEAN (clean range for the current chunk), INV (invalidate range for the current chunk) and DONE (completion pulse). Its transitions are: IDLE to HEAD, TAIL, CLEAN, INV or DONE on acceptance, depending on the operation, the edges and the override. HEAD goes to TAIL, INV or DONE. TAIL goes to INV or DONE. CLEAN goes to INV when the operation is a flush, and otherwise to CLEAN for the next chunk or to DONE. INV goes to CLEAN (flush without override), to INV (next chunk) or to DONE. DONE always returns to IDLE. HEAD, TAIL, CLEAN and INV only move on a command handshake.

Top module: `mrc_seq`

## Requirements
- R1: The operation code is 0 for invalidate, 1 for clean and 2 for flush, and code 3 is treated as clean. The command kind is 0 for single-line clean+invalidate, 1 for range clean and 2 for range invalidate. Lines are 32 bytes. Every command start is line aligned, and every command end is the address of the last line covered: chunk end minus 32. A single-line command has its start equal to its end.
- R2: No range command covers more than 1024 bytes (the chunk budget).
- R3: A range command never crosses a 4096-byte page boundary. Its chunk end is the smallest of the request limit, the start plus the budget, and the next page start above the chunk start.
- R4: For invalidate with a start that is not line aligned, the first command is a single-line clean+invalidate of the line holding the start. Processing then continues from the next line boundary.
- R5: For invalidate, after the head step, if the start is still below the end and the end is not line aligned, a single-line clean+invalidate of the line holding the end is emitted. The end is then rounded down to a line boundary.
- R6: For clean and flush, the start is rounded down and the end is rounded up to line boundaries before chunking, and a clean request emits one range clean per chunk.
- R7: With the override set at acceptance, a clean request emits no commands, and a flush emits only one range invalidate per chunk.
- R8: A flush without the override emits, for each chunk, a range clean followed by a range invalidate over the same addresses.
- R9: A request that is empty after edge handling emits no commands, and done is high in the cycle after acceptance.
- R10: A command stays valid and unchanged until cmd_ready is high. Done is a one-cycle pulse in the cycle after the last handshake. req_ready is high only while idle, and never at the same time as cmd_valid or done.
- R11: For invalidate, commands come in the order head line, tail line, then range invalidates in ascending address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_override | input | 1 | Write-through override, sampled on request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | Operation code (R1) |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end byte address |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Line range engine takes the command |
| cmd_kind | output | 2 | Command kind (R1) |
| cmd_start | output | AW | Line-aligned first address |
| cmd_end | output | AW | Inclusive last line address |
| done | output | 1 | One-cycle completion pulse |

## Verification
A request is taken at the rising edge where req_valid and req_ready are both high. The first command is valid in the cycle that follows, and each later command appears in the cycle after the handshake of the one before it. Done is due exactly one cycle after the last handshake, or one cycle after acceptance for an empty request, and req_ready returns in the cycle after done. The bench drives inputs and samples outputs on falling edges. It randomises cmd_ready to create stalls, and it flags a missing or early done, as well as any extra or missing command, against a command list built by its own model of the requirements.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2
    } mrc_op_e;

    typedef enum logic [1:0] {
        CMD_LINE_CLINV  = 2'd0,
        CMD_RANGE_CLEAN = 2'd1,
        CMD_RANGE_INV   = 2'd2
    } mrc_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HEAD  = 3'd1,
        ST_TAIL  = 3'd2,
        ST_CLEAN = 3'd3,
        ST_INV   = 3'd4,
        ST_DONE  = 3'd5
    } mrc_state_e;

endpackage

// File: rtl/mrc_edge_align.sv
// Edge handling of a request: partial head/tail lines for invalidate,
// outward rounding for clean and flush.
module mrc_edge_align
    import mrc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  mrc_op_e          op,
    input  logic [AW-1:0]    start_addr,
    input  logic [AW-1:0]    stop_addr,
    output logic             head_need,
    output logic [AW-1:0]    head_line,
    output logic             tail_need,
    output logic [AW-1:0]    tail_line,
    output logic [AW-1:0]    walk_start,
    output logic [AW-1:0]    walk_limit
);

    localparam logic [AW-1:0] LMASK  = AW'(LINE_BYTES - 1);
    localparam logic [AW-1:0] LINE_A = AW'(LINE_BYTES);

    logic [AW-1:0] s_floor;
    logic [AW-1:0] s_next;
    logic [AW-1:0] e_floor;
    logic [AW-1:0] e_ceil;
    logic          s_ragged;
    logic          e_ragged;

    always_comb begin
        s_floor  = start_addr & ~LMASK;
        s_next   = s_floor + LINE_A;
        e_floor  = stop_addr & ~LMASK;
        e_ceil   = (stop_addr + LMASK) & ~LMASK;
        s_ragged = |(start_addr & LMASK);
        e_ragged = |(stop_addr & LMASK);
        head_line = s_floor;
        tail_line = e_floor;

        if (op == OP_INV) begin
            head_need  = s_ragged;
            walk_start = s_ragged ? s_next : start_addr;
            tail_need  = (walk_start < stop_addr) && e_ragged;
            walk_limit = tail_need ? e_floor : stop_addr;
        end else begin
            head_need  = 1'b0;
            tail_need  = 1'b0;
            walk_start = s_floor;
            walk_limit = e_ceil;
        end
    end

endmodule

// File: rtl/mrc_chunk_limit.sv
// End of the current chunk (exclusive): the smallest of the walk limit,
// the byte budget and the next page start.
module mrc_chunk_limit #(
    parameter int AW              = 32,
    parameter int MAX_CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES      = 4096
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] lim,
    output logic [AW-1:0] chunk_stop
);

    localparam logic [AW-1:0] PMASK  = AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] PAGE_A = AW'(PAGE_BYTES);
    localparam logic [AW-1:0] MAX_A  = AW'(MAX_CHUNK_BYTES);

    logic [AW-1:0] by_size;
    logic [AW-1:0] by_page;
    logic [AW-1:0] first_cut;

    always_comb begin
        by_size    = cur + MAX_A;
        by_page    = (cur & ~PMASK) + PAGE_A;
        first_cut  = (lim < by_size) ? lim : by_size;
        chunk_stop = (first_cut < by_page) ? first_cut : by_page;
    end

endmodule

// File: rtl/mrc_seq.sv
module mrc_seq
    import mrc_pkg::*;
#(
    parameter int AW              = 32,
    parameter int LINE_BYTES      = 32,
    parameter int MAX_CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES      = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wt_override,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_end,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [1:0]    cmd_kind,
    output logic [AW-1:0] cmd_start,
    output logic [AW-1:0] cmd_end,
    output logic          done
);

    localparam logic [AW-1:0] LINE_A = AW'(LINE_BYTES);

    mrc_state_e    state_q, state_d;
    mrc_op_e       op_q;
    logic          wt_q;
    logic [AW-1:0] cur_q, lim_q;
    logic          tail_q;
    logic [AW-1:0] head_line_q, tail_line_q;

    mrc_op_e       req_op_eff;
    logic          a_head, a_tail;
    logic [AW-1:0] a_head_line, a_tail_line, a_walk_start, a_walk_limit;
    logic [AW-1:0] chunk_stop;
    logic          accept;
    logic          step;

    // Code 3 is folded onto clean.
    always_comb begin
        unique case (req_op)
            2'd0:    req_op_eff = OP_INV;
            2'd2:    req_op_eff = OP_FLUSH;
            default: req_op_eff = OP_CLEAN;
        endcase
    end

    mrc_edge_align #(
        .AW         (AW),
        .LINE_BYTES (LINE_BYTES)
    ) u_align (
        .op         (req_op_eff),
        .start_addr (req_start),
        .stop_addr  (req_end),
        .head_need  (a_head),
        .head_line  (a_head_line),
        .tail_need  (a_tail),
        .tail_line  (a_tail_line),
        .walk_start (a_walk_start),
        .walk_limit (a_walk_limit)
    );

    mrc_chunk_limit #(
        .AW              (AW),
        .MAX_CHUNK_BYTES (MAX_CHUNK_BYTES),
        .PAGE_BYTES      (PAGE_BYTES)
    ) u_chunk (
        .cur        (cur_q),
        .lim        (lim_q),
        .chunk_stop (chunk_stop)
    );

    function automatic mrc_state_e walk_entry(input mrc_op_e op, input logic wt);
        unique case (op)
            OP_INV:   walk_entry = ST_INV;
            OP_FLUSH: walk_entry = wt ? ST_INV : ST_CLEAN;
            default:  walk_entry = ST_CLEAN;
        endcase
    endfunction

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_op_eff == OP_CLEAN && wt_override)
                        state_d = ST_DONE;
                    else if (a_head)
                        state_d = ST_HEAD;
                    else if (a_tail)
                        state_d = ST_TAIL;
                    else if (a_walk_start < a_walk_limit)
                        state_d = walk_entry(req_op_eff, wt_override);
                    else
                        state_d = ST_DONE;
                end
            end
            ST_HEAD: begin
                if (cmd_ready) begin
                    if (tail_q)
                        state_d = ST_TAIL;
                    else if (cur_q < lim_q)
                        state_d = ST_INV;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_TAIL: begin
                if (cmd_ready)
                    state_d = (cur_q < lim_q) ? ST_INV : ST_DONE;
            end
            ST_CLEAN: begin
                if (cmd_ready) begin
                    if (op_q == OP_FLUSH)
                        state_d = ST_INV;
                    else
                        state_d = (chunk_stop < lim_q) ? ST_CLEAN : ST_DONE;
                end
            end
            ST_INV: begin
                if (cmd_ready) begin
                    if (chunk_stop < lim_q)
                        state_d = (op_q == OP_FLUSH && !wt_q) ? ST_CLEAN : ST_INV;
                    else
                        state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // The walk pointer moves past a chunk once its last command is taken.
    always_comb begin
        step = 1'b0;
        if (cmd_ready) begin
            if (state_q == ST_INV)
                step = 1'b1;
            else if (state_q == ST_CLEAN && op_q != OP_FLUSH)
                step = 1'b1;
        end
    end

    // Request context and walk pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_INV;
            wt_q        <= 1'b0;
            cur_q       <= '0;
            lim_q       <= '0;
            tail_q      <= 1'b0;
            head_line_q <= '0;
            tail_line_q <= '0;
        end else if (accept) begin
            op_q        <= req_op_eff;
            wt_q        <= wt_override;
            cur_q       <= a_walk_start;
            lim_q       <= a_walk_limit;
            tail_q      <= a_tail;
            head_line_q <= a_head_line;
            tail_line_q <= a_tail_line;
        end else if (step) begin
            cur_q <= chunk_stop;
        end
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        done      = 1'b0;
        cmd_valid = 1'b0;
        cmd_kind  = CMD_LINE_CLINV;
        cmd_start = '0;
        cmd_end   = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_HEAD: begin
                cmd_valid = 1'b1;
                cmd_kind  = CMD_LINE_CLINV;
                cmd_start = head_line_q;
                cmd_end   = head_line_q;
            end
            ST_TAIL: begin
                cmd_valid = 1'b1;
                cmd_kind  = CMD_LINE_CLINV;
                cmd_start = tail_line_q;
                cmd_end   = tail_line_q;
            end
            ST_CLEAN: begin
                cmd_valid = 1'b1;
                cmd_kind  = CMD_RANGE_CLEAN;
                cmd_start = cur_q;
                cmd_end   = chunk_stop - LINE_A;
            end
            ST_INV: begin
                cmd_valid = 1'b1;
                cmd_kind  = CMD_RANGE_INV;
                cmd_start = cur_q;
                cmd_end   = chunk_stop - LINE_A;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/mrc_seq_chk.sv
module mrc_seq_chk #(
    parameter int AW              = 32,
    parameter int LINE_BYTES      = 32,
    parameter int MAX_CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES      = 4096
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [1:0]    cmd_kind,
    input logic [AW-1:0] cmd_start,
    input logic [AW-1:0] cmd_end,
    input logic          done
);

    localparam logic [AW-1:0] LMASK  = AW'(LINE_BYTES - 1);
    localparam logic [AW-1:0] LINE_A = AW'(LINE_BYTES);
    localparam logic [AW-1:0] PMASK  = AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] MAX_A  = AW'(MAX_CHUNK_BYTES);

    // R10: a stalled command is held unchanged
    assert_hold_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind)
                                    && $stable(cmd_start) && $stable(cmd_end));

    // R1: aligned start, inclusive end on the last line
    assert_line_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cmd_start & LMASK) == '0) && ((cmd_end & LMASK) == '0)
                      && (cmd_end >= cmd_start));

    // R1: single-line commands cover exactly one line
    assert_single_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 2'd0 |-> cmd_start == cmd_end);

    // R2: chunk budget
    assert_chunk_budget_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_end - cmd_start + LINE_A) <= MAX_A);

    // R3: no page crossing
    assert_same_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_start & ~PMASK) == (cmd_end & ~PMASK));

    // R10: done is a lone pulse, exclusive with command and request phases
    assert_done_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_valid && !req_ready);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);

    // R1: only defined command kinds
    assert_kind_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_kind != 2'd3);

endmodule

bind mrc_seq mrc_seq_chk #(
    .AW              (AW),
    .LINE_BYTES      (LINE_BYTES),
    .MAX_CHUNK_BYTES (MAX_CHUNK_BYTES),
    .PAGE_BYTES      (PAGE_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_kind  (cmd_kind),
    .cmd_start (cmd_start),
    .cmd_end   (cmd_end),
    .done      (done)
);

// File: tb/sim_mrc_seq.sv
`timescale 1ns/1ps
module sim_mrc_seq;

    localparam int AW = 32;
    localparam logic [31:0] LINE = 32'd32;
    localparam logic [31:0] MAXC = 32'd1024;
    localparam logic [31:0] PAGE = 32'd4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wt_override = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_start;
    logic [AW-1:0] cmd_end;
    logic          done;

    int n_chk = 0;
    int n_err = 0;

    logic [1:0]  exp_k [256];
    logic [31:0] exp_s [256];
    logic [31:0] exp_e [256];
    string       exp_t [256];
    int          n_exp;

    always #5 clk = ~clk;

    mrc_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wt_override (wt_override),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_start   (req_start),
        .req_end     (req_end),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_kind    (cmd_kind),
        .cmd_start   (cmd_start),
        .cmd_end     (cmd_end),
        .done        (done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] chunk_stop(input logic [31:0] cur, input logic [31:0] lim);
        logic [31:0] r;
        logic [31:0] pg;
        r  = lim;
        if (r > cur + MAXC) r = cur + MAXC;
        pg = (cur | (PAGE - 1)) + 1;
        if (r > pg) r = pg;
        return r;
    endfunction

    task automatic push(input logic [1:0] k, input logic [31:0] s, input logic [31:0] e,
                        input string t);
        exp_k[n_exp] = k;
        exp_s[n_exp] = s;
        exp_e[n_exp] = e;
        exp_t[n_exp] = t;
        n_exp++;
    endtask

    // Expected command list (kind 0 line clean+inv, 1 range clean, 2 range inv).
    task automatic model(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                         input bit wt);
        logic [31:0] cur;
        logic [31:0] lim;
        logic [31:0] ce;
        n_exp = 0;
        if (op == 2'd0) begin
            cur = s;
            lim = e;
            if ((cur & (LINE - 1)) != 0) begin
                push(2'd0, cur & ~(LINE - 1), cur & ~(LINE - 1), "R4");
                cur = (cur | (LINE - 1)) + 1;
            end
            if (cur < lim && (lim & (LINE - 1)) != 0) begin
                push(2'd0, lim & ~(LINE - 1), lim & ~(LINE - 1), "R5");
                lim = lim & ~(LINE - 1);
            end
            while (cur < lim) begin
                ce = chunk_stop(cur, lim);
                push(2'd2, cur, ce - LINE, "R11");
                cur = ce;
            end
        end else begin
            cur = s & ~(LINE - 1);
            lim = (e + LINE - 1) & ~(LINE - 1);
            while (cur < lim) begin
                ce = chunk_stop(cur, lim);
                if (op == 2'd2) begin
                    if (!wt) push(2'd1, cur, ce - LINE, "R8");
                    push(2'd2, cur, ce - LINE, wt ? "R7" : "R8");
                end else if (!wt) begin
                    push(2'd1, cur, ce - LINE, "R6");
                end
                cur = ce;
            end
        end
    endtask

    // Issue one request at a falling edge and follow it to done.
    task automatic run_req(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                           input bit wt, input bit always_ready);
        int  idx;
        int  cyc;
        bit  got_done;
        bit  due;
        bit  rdy;
        model(op, s, e, wt);
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "req_ready before request", 32'(req_ready), 32'd1);
        req_valid   = 1'b1;
        req_op      = op;
        req_start   = s;
        req_end     = e;
        wt_override = wt;
        @(negedge clk);
        req_valid   = 1'b0;
        wt_override = 1'b0;
        idx = 0;
        cyc = 0;
        got_done = 1'b0;
        due = (n_exp == 0);
        while (!got_done && cyc < 4000) begin
            if (done) begin
                check(idx == n_exp, (n_exp == 0) ? ((op == 2'd1 && wt) ? "R7" : "R9") : "R10",
                      "commands seen at done", 32'(idx), 32'(n_exp));
                check(due, "R10", "done timing after last handshake", 32'(due), 32'd1);
                got_done = 1'b1;
                cmd_ready = 1'b0;
            end else begin
                if (due)
                    check(1'b0, (n_exp == 0) ? "R9" : "R10", "done missing when due",
                          32'(done), 32'd1);
                due = 1'b0;
                if (cmd_valid) begin
                    if (idx >= n_exp) begin
                        check(1'b0, "R11", "extra command start", cmd_start, 32'hFFFF_FFFF);
                    end else begin
                        check(cmd_kind == exp_k[idx], exp_t[idx], "command kind",
                              32'(cmd_kind), 32'(exp_k[idx]));
                        check(cmd_start == exp_s[idx], exp_t[idx], "command start",
                              cmd_start, exp_s[idx]);
                        check(cmd_end == exp_e[idx], exp_t[idx], "command end",
                              cmd_end, exp_e[idx]);
                    end
                end
                rdy = always_ready ? 1'b1 : (($urandom % 10) < 7);
                cmd_ready = rdy;
                if (cmd_valid && rdy) begin
                    idx++;
                    due = (idx == n_exp);
                end
                @(negedge clk);
                cyc++;
            end
        end
        if (!got_done)
            check(1'b0, "R10", "done never seen", 32'(idx), 32'(n_exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R10", "reset req_ready", 32'(req_ready), 32'd1);
        check(cmd_valid == 1'b0, "R10", "reset cmd_valid", 32'(cmd_valid), 32'd0);
        check(done == 1'b0, "R10", "reset done", 32'(done), 32'd0);

        // Directed corners.
        run_req(2'd0, 32'h0000_0010, 32'h0000_0878, 1'b0, 1'b1); // R4 R5 R2 head+tail+chunks
        run_req(2'd1, 32'h0000_0F04, 32'h0000_1101, 1'b0, 1'b0); // R6 R3 page split
        run_req(2'd2, 32'h0000_2000, 32'h0000_2C00, 1'b0, 1'b0); // R8 pairs
        run_req(2'd2, 32'h0000_2000, 32'h0000_2C00, 1'b1, 1'b1); // R7 flush inv only
        run_req(2'd1, 32'h0000_0100, 32'h0000_0900, 1'b1, 1'b1); // R7 clean nothing
        run_req(2'd0, 32'h0000_0105, 32'h0000_010A, 1'b0, 1'b1); // R4 head only, no tail
        run_req(2'd0, 32'h0000_0200, 32'h0000_0200, 1'b0, 1'b1); // R9 empty
        run_req(2'd1, 32'h0000_0340, 32'h0000_0340, 1'b0, 1'b0); // R9 empty clean
        run_req(2'd0, 32'h0000_0400, 32'h0000_0413, 1'b0, 1'b1); // R5 tail only
        run_req(2'd3, 32'h0000_0FF0, 32'h0000_1010, 1'b0, 1'b1); // R1 code 3 as clean
        run_req(2'd0, 32'h0000_0C20, 32'h0000_2000, 1'b0, 1'b0); // R3 R2 inv over page

        for (int i = 0; i < 300; i++) begin
            logic [31:0] s;
            logic [31:0] len;
            s   = $urandom % 32768;
            len = ((i % 4) == 0) ? ($urandom % 80) : ($urandom % 6144);
            run_req(2'($urandom % 3), s, s + len, bit'($urandom % 2), bit'((i % 5) == 0));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule